// File: doc/BRIEF.md
# Host Bus Cycle Decoder Tracker

This block sits beside a processor's front-side bus on the system side and follows each bus cycle from its address strobe to its final ready. In the clock where the strobe is high it captures the cycle-definition inputs: code/data, memory/I/O, write/read and the active-low line-fill hint. It turns them into a cycle-type code and decides whether the cycle is one transfer or a four-transfer burst. It then counts ready responses until the cycle ends.

A write that carries the hint is a burst from the start. A read that carries the hint is only a candidate. It becomes a burst only if system logic returns the line-enable input in the same clock as the first ready. Otherwise it ends after that one ready. I/O, interrupt-acknowledge and special cycles always take a single transfer. The block also watches protocol: a strobe while a cycle is still open is an error. An interrupt acknowledge must be followed directly by a second one, and the block holds a lock indication across the pair.

Top module: `hbc_tracker`

## Requirements
- R1: After synchronous active-high reset, cyc_active, burst, code_fetch, cyc_done, pair_lock and proto_err are 0, cyc_type is 0 (none) and beat_idx is 0.
- R2: A strobe while idle opens a cycle. From the next clock cyc_active is 1 and cyc_type is decoded as follows: mem_sel=1 gives a memory type; mem_sel=0 with is_data=1 gives I/O (3); mem_sel=0, is_data=0, wr_sel=0 gives interrupt acknowledge (4); mem_sel=0, is_data=0, wr_sel=1 gives special (5).
- R3: A memory write with line_hint_n=0 shows cyc_type 2 (memory burst) and burst=1 from the first open clock, and it ends after exactly four rdy pulses.
- R4: A memory read with line_hint_n=0 shows cyc_type 1 and burst=0 until its first rdy. If line_ok is 1 with that rdy, it turns into cyc_type 2 with burst=1 and ends after four rdy pulses in total. Otherwise it ends after that single rdy.
- R5: A memory cycle with line_hint_n=1 shows cyc_type 1 (memory single) and ends after one rdy, whatever line_ok is.
- R6: I/O, interrupt-acknowledge and special cycles never burst, whatever line_hint_n and line_ok are. Each ends after one rdy.
- R7: While a cycle is open, beat_idx equals the number of rdy pulses already accepted in it (0 to 3). It returns to 0 when the cycle ends.
- R8: cyc_done is a one-clock pulse in the clock after the final rdy. cyc_active falls in that same clock and cyc_type returns to 0.
- R9: rdy and line_ok have no effect while no cycle is open.
- R10: A strobe while a cycle is open gives a one-clock proto_err pulse in the next clock and is otherwise ignored. The open cycle keeps its type and transfer count.
- R11: An interrupt acknowledge raises pair_lock from the clock after its strobe. pair_lock stays high until the second interrupt acknowledge ends. If the next strobe after the first one ends is not an interrupt acknowledge, proto_err pulses, pair_lock drops and the new cycle proceeds normally.
- R12: code_fetch is 1 during an open memory cycle whose is_data was 0, and 0 for every other cycle and when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strobe | input | 1 | Address strobe, high for the clock that starts a cycle |
| is_data | input | 1 | 1 = data access, 0 = code access |
| mem_sel | input | 1 | 1 = memory, 0 = I/O space |
| wr_sel | input | 1 | 1 = write, 0 = read |
| line_hint_n | input | 1 | Active-low line-fill (burst) hint |
| rdy | input | 1 | Transfer ready from system logic |
| line_ok | input | 1 | Line-enable from system logic, sampled with the first rdy of a read |
| cyc_active | output | 1 | A cycle is open |
| cyc_type | output | 3 | 0 none, 1 memory single, 2 memory burst, 3 I/O, 4 interrupt acknowledge, 5 special |
| burst | output | 1 | The open cycle is a four-transfer burst |
| beat_idx | output | 2 | Transfers already accepted in the open cycle |
| code_fetch | output | 1 | The open memory cycle is a code access |
| cyc_done | output | 1 | One-clock pulse after the final transfer |
| pair_lock | output | 1 | An interrupt-acknowledge pair is in progress |
| proto_err | output | 1 | One-clock pulse on a protocol violation |

## Verification
The bench drives a hinted read twice. In one run line_ok comes with the first ready; in the other it is absent or comes only on a later ready. A design that settles the burst at the strobe or at a later ready would end the fallback read too late, or the confirmed read too early. It also sends hinted I/O and special cycles with line_ok high, where a design that ignored the space bit would wait for four readies. Overlapping strobes and a broken interrupt-acknowledge pair are driven to check that the error pulses in the right clock and that the open cycle keeps its count. A design that restarted on the stray strobe would show a reset transfer count. Readies sent while idle check that no phantom cycle or done pulse appears.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    typedef enum logic [2:0] {
        CT_NONE     = 3'd0,
        CT_MEM_ONE  = 3'd1,
        CT_MEM_LINE = 3'd2,
        CT_IO       = 3'd3,
        CT_INTA     = 3'd4,
        CT_SPEC     = 3'd5
    } cyc_kind_e;

endpackage

// File: rtl/hbc_decode.sv
module hbc_decode
    import hbc_pkg::*;
(
    input  logic      is_data,
    input  logic      mem_sel,
    input  logic      wr_sel,
    input  logic      line_hint_n,
    output cyc_kind_e kind,
    output logic      line_now,
    output logic      line_cand,
    output logic      code_acc
);

    always_comb begin
        kind      = CT_NONE;
        line_now  = 1'b0;
        line_cand = 1'b0;
        code_acc  = 1'b0;
        if (mem_sel) begin
            code_acc = !is_data;
            if (!line_hint_n) begin
                if (wr_sel) begin
                    // hinted write: burst is fixed at the strobe
                    kind     = CT_MEM_LINE;
                    line_now = 1'b1;
                end else begin
                    // hinted read: only a candidate until the first ready
                    kind      = CT_MEM_ONE;
                    line_cand = 1'b1;
                end
            end else begin
                kind = CT_MEM_ONE;
            end
        end else if (is_data) begin
            kind = CT_IO;
        end else if (wr_sel) begin
            kind = CT_SPEC;
        end else begin
            kind = CT_INTA;
        end
    end

endmodule

// File: rtl/hbc_beat.sv
module hbc_beat #(
    parameter int BEATS = 4,
    localparam int W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         adv,
    input  logic         last,
    output logic [W-1:0] beat
);

    logic [W-1:0] beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (clear || last) begin
            beat_d = '0;
        end else if (adv) begin
            beat_d = beat_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign beat = beat_q;

    // R7
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !last && !clear) |=> (beat_q == $past(beat_q) + W'(1)));

    // R7
    beat_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> (beat_q == '0));

endmodule

// File: rtl/hbc_pair_mon.sv
module hbc_pair_mon (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_inta,
    input  logic finish,
    output logic pair_break,
    output logic lock
);

    typedef struct packed {
        logic first;
        logic pend;
        logic second;
    } pair_t;

    pair_t p_d, p_q;

    assign pair_break = start && p_q.pend && !start_inta;

    always_comb begin
        p_d = p_q;
        if (start) begin
            if (p_q.pend) begin
                p_d.pend   = 1'b0;
                p_d.second = start_inta;
            end else begin
                p_d.first = start_inta;
            end
        end else if (finish) begin
            if (p_q.first) begin
                p_d.first = 1'b0;
                p_d.pend  = 1'b1;
            end
            p_d.second = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign lock = p_q.first || p_q.pend || p_q.second;

    // R11
    pair_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (finish && p_q.first && !start) |=> p_q.pend);

    // R11
    pair_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (start && p_q.pend) |=> !p_q.pend);

    // R11
    pair_state_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({p_q.first, p_q.pend, p_q.second}));

endmodule

// File: rtl/hbc_tracker.sv
module hbc_tracker
    import hbc_pkg::*;
#(
    parameter int BURST_BEATS = 4,
    localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_strobe,
    input  logic              is_data,
    input  logic              mem_sel,
    input  logic              wr_sel,
    input  logic              line_hint_n,
    input  logic              rdy,
    input  logic              line_ok,
    output logic              cyc_active,
    output logic [2:0]        cyc_type,
    output logic              burst,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              code_fetch,
    output logic              cyc_done,
    output logic              pair_lock,
    output logic              proto_err
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);

    typedef struct packed {
        logic      active;
        cyc_kind_e kind;
        logic      line;
        logic      cand;
        logic      code;
        logic      done;
        logic      err;
    } trk_t;

    trk_t s_d, s_q;

    cyc_kind_e         dec_kind;
    logic              dec_line, dec_cand, dec_code;
    logic              start, adv, confirm, line_eff, last;
    logic              pair_break;
    logic [BEAT_W-1:0] beat;

    hbc_decode u_dec (
        .is_data    (is_data),
        .mem_sel    (mem_sel),
        .wr_sel     (wr_sel),
        .line_hint_n(line_hint_n),
        .kind       (dec_kind),
        .line_now   (dec_line),
        .line_cand  (dec_cand),
        .code_acc   (dec_code)
    );

    assign start    = addr_strobe && !s_q.active;
    assign adv      = s_q.active && rdy;
    assign confirm  = adv && s_q.cand && (beat == '0) && line_ok;
    assign line_eff = s_q.line || confirm;
    assign last     = adv && (line_eff ? (beat == LAST_BEAT) : 1'b1);

    hbc_beat #(.BEATS(BURST_BEATS)) u_beat (
        .clk  (clk),
        .rst  (rst),
        .clear(start),
        .adv  (adv),
        .last (last),
        .beat (beat)
    );

    hbc_pair_mon u_pair (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_inta(dec_kind == CT_INTA),
        .finish    (last),
        .pair_break(pair_break),
        .lock      (pair_lock)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = (addr_strobe && s_q.active) || pair_break;
        if (start) begin
            s_d.active = 1'b1;
            s_d.kind   = dec_kind;
            s_d.line   = dec_line;
            s_d.cand   = dec_cand;
            s_d.code   = dec_code;
        end else if (adv) begin
            s_d.cand = 1'b0;
            if (confirm) begin
                s_d.line = 1'b1;
                s_d.kind = CT_MEM_LINE;
            end
            if (last) begin
                s_d.active = 1'b0;
                s_d.kind   = CT_NONE;
                s_d.line   = 1'b0;
                s_d.code   = 1'b0;
                s_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{active: 1'b0, kind: CT_NONE, line: 1'b0, cand: 1'b0,
                     code: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cyc_active = s_q.active;
    assign cyc_type   = s_q.kind;
    assign burst      = s_q.line;
    assign beat_idx   = beat;
    assign code_fetch = s_q.code && s_q.active;
    assign cyc_done   = s_q.done;
    assign proto_err  = s_q.err;

    // R10
    overlap_err_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_strobe && cyc_active) |=> proto_err);

    // R10
    overlap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_strobe && cyc_active && !rdy) |=> (cyc_active && $stable(cyc_type)));

    // R8
    done_closed_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_done |-> (!cyc_active && cyc_type == 3'd0));

    // R6
    other_single_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_active && rdy && (cyc_type == 3'd3 || cyc_type == 3'd4 || cyc_type == 3'd5))
        |=> (!cyc_active && cyc_done));

    // R4
    read_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_active && cyc_type == 3'd1 && rdy && !line_ok) |=> (!cyc_active && cyc_done));

    // R3
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_active && burst && rdy && beat_idx != LAST_BEAT) |=> (cyc_active && burst));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cyc_active && !addr_strobe) |=> !cyc_active);

endmodule

// File: tb/sim_hbc_tracker.sv
module sim_hbc_tracker;

    logic       clk = 1'b0;
    logic       rst;
    logic       addr_strobe, is_data, mem_sel, wr_sel, line_hint_n, rdy, line_ok;
    logic       cyc_active, burst, code_fetch, cyc_done, pair_lock, proto_err;
    logic [2:0] cyc_type;
    logic [1:0] beat_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hbc_tracker u0 (
        .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .is_data(is_data),
        .mem_sel(mem_sel), .wr_sel(wr_sel), .line_hint_n(line_hint_n),
        .rdy(rdy), .line_ok(line_ok), .cyc_active(cyc_active),
        .cyc_type(cyc_type), .burst(burst), .beat_idx(beat_idx),
        .code_fetch(code_fetch), .cyc_done(cyc_done), .pair_lock(pair_lock),
        .proto_err(proto_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // raise strobe for one clock; returns at the following negedge
    task automatic strobe(input logic d, input logic m, input logic w, input logic hn);
        addr_strobe = 1'b1; is_data = d; mem_sel = m; wr_sel = w; line_hint_n = hn;
        @(posedge clk); @(negedge clk);
        addr_strobe = 1'b0;
    endtask

    task automatic ready(input logic ok);
        rdy = 1'b1; line_ok = ok;
        @(posedge clk); @(negedge clk);
        rdy = 1'b0; line_ok = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 active", cyc_active, 0);
        chk("R1 type", cyc_type, 0);
        chk("R1 burst", burst, 0);
        chk("R1 beat", beat_idx, 0);
        chk("R1 done", cyc_done, 0);
        chk("R1 err", proto_err, 0);
        chk("R1 lock", pair_lock, 0);
        chk("R1 code", code_fetch, 0);
    endtask

    task automatic t_write_burst();
        strobe(1, 1, 1, 0);
        chk("R2 active", cyc_active, 1);
        chk("R3 type", cyc_type, 2);
        chk("R3 burst", burst, 1);
        chk("R12 data write", code_fetch, 0);
        for (int i = 1; i <= 3; i++) begin
            ready(0);
            chk("R7 beat", beat_idx, i);
            chk("R3 still open", cyc_active, 1);
        end
        ready(0);
        chk("R8 done", cyc_done, 1);
        chk("R8 closed", cyc_active, 0);
        chk("R8 type none", cyc_type, 0);
        chk("R7 beat wrap", beat_idx, 0);
        idle(1);
        chk("R8 pulse one", cyc_done, 0);
    endtask

    task automatic t_read_confirm();
        strobe(0, 1, 0, 0);
        chk("R4 cand type", cyc_type, 1);
        chk("R4 cand burst", burst, 0);
        chk("R12 code read", code_fetch, 1);
        ready(1);
        chk("R4 confirmed type", cyc_type, 2);
        chk("R4 confirmed burst", burst, 1);
        chk("R7 beat1", beat_idx, 1);
        ready(0); ready(0);
        chk("R4 open before 4th", cyc_active, 1);
        ready(0);
        chk("R4 done after 4", cyc_done, 1);
        idle(1);
    endtask

    task automatic t_read_fallback();
        strobe(1, 1, 0, 0);
        ready(0);
        chk("R4 fallback closed", cyc_active, 0);
        chk("R4 fallback done", cyc_done, 1);
        idle(1);
        // line_ok arriving only after the first ready does not matter: already closed
        chk("R4 no reopen", cyc_active, 0);
    endtask

    task automatic t_mem_single();
        strobe(0, 1, 1, 1);
        chk("R5 type", cyc_type, 1);
        ready(1);
        chk("R5 one beat", cyc_done, 1);
        chk("R5 closed", cyc_active, 0);
        idle(1);
    endtask

    task automatic t_io();
        strobe(1, 0, 0, 0);
        chk("R2 io type", cyc_type, 3);
        chk("R6 io burst", burst, 0);
        chk("R12 io code", code_fetch, 0);
        ready(1);
        chk("R6 io single", cyc_done, 1);
        chk("R6 io closed", cyc_active, 0);
        idle(1);
    endtask

    task automatic t_special();
        strobe(0, 0, 1, 0);
        chk("R2 special type", cyc_type, 5);
        ready(1);
        chk("R6 special single", cyc_done, 1);
        idle(1);
    endtask

    task automatic t_idle_rdy();
        rdy = 1'b1; line_ok = 1'b1;
        idle(3);
        rdy = 1'b0; line_ok = 1'b0;
        chk("R9 idle active", cyc_active, 0);
        chk("R9 idle done", cyc_done, 0);
        chk("R9 idle beat", beat_idx, 0);
    endtask

    task automatic t_overlap();
        strobe(1, 1, 1, 0);
        ready(0);
        strobe(1, 0, 0, 1);
        chk("R10 err", proto_err, 1);
        chk("R10 type kept", cyc_type, 2);
        chk("R10 beat kept", beat_idx, 1);
        idle(1);
        chk("R10 err pulse", proto_err, 0);
        ready(0); ready(0);
        chk("R10 open", cyc_active, 1);
        ready(0);
        chk("R10 completes", cyc_done, 1);
        idle(1);
    endtask

    task automatic t_inta_pair();
        strobe(0, 0, 0, 0);
        chk("R2 inta type", cyc_type, 4);
        chk("R11 lock first", pair_lock, 1);
        ready(1);
        chk("R6 inta single", cyc_done, 1);
        chk("R11 lock between", pair_lock, 1);
        idle(2);
        strobe(0, 0, 0, 1);
        chk("R11 second no err", proto_err, 0);
        chk("R11 lock second", pair_lock, 1);
        ready(0);
        chk("R11 lock released", pair_lock, 0);
        idle(1);
    endtask

    task automatic t_inta_broken();
        strobe(0, 0, 0, 0);
        ready(0);
        strobe(1, 1, 0, 1);
        chk("R11 break err", proto_err, 1);
        chk("R11 break lock", pair_lock, 0);
        chk("R11 break type", cyc_type, 1);
        ready(0);
        chk("R11 break completes", cyc_done, 1);
        idle(1);
    endtask

    initial begin
        rst = 1'b1; addr_strobe = 0; is_data = 0; mem_sel = 0; wr_sel = 0;
        line_hint_n = 1; rdy = 0; line_ok = 0;
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_write_burst();
        t_read_confirm();
        t_read_fallback();
        t_mem_single();
        t_io();
        t_special();
        t_idle_rdy();
        t_overlap();
        t_inta_pair();
        t_inta_broken();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule